// File: doc/BRIEF.md
# Two-Level Local History Branch Predictor

This block predicts the direction of conditional branches from each branch's own past behaviour. The first level is a small table of per-branch outcome histories, selected by low bits of the branch address. The chosen history is XOR-ed with a wider slice of the address to pick one 2-bit saturating counter in a second-level table. The upper bit of that counter is the prediction.

The fetch stage presents address bits and gets back, in the same cycle, a taken/not-taken guess and the counter index that produced it. The index travels down the pipeline with the branch. When the branch resolves, the execute stage returns the address bits, that stored index and the real outcome. The predictor then trains the named counter and shifts the outcome into that branch's history. Lookups are combinational from registered tables, so an update lands at the clock edge after it is presented.

Top module: `lhp_predictor`

## Requirements
- R1: The history slot is PC[7:2] (the low 6 bits of `pred_pc`). `pred_index` equals PC[11:2] XOR the 10-bit history held in that slot, in the same cycle.
- R2: `pred_taken` is 1 exactly when the counter at `pred_index` holds 2 or 3.
- R3: After reset every history is 0 and every counter is 1. `pred_index` then equals `pred_pc` and `pred_taken` is 0 for all addresses.
- R4: An update with `upd_taken`=1 raises the counter at `upd_index` by one, and a counter at 3 stays at 3.
- R5: An update with `upd_taken`=0 lowers the counter at `upd_index` by one, and a counter at 0 stays at 0.
- R6: An update shifts the history in slot `upd_pc` left by one, puts the outcome into bit 0 and drops the oldest bit.
- R7: The counter trained is the one named by `upd_index`, with no recomputation from the address or the current history.
- R8: While `upd_valid` is 0, the values on `upd_pc`, `upd_index` and `upd_taken` change no history and no counter.
- R9: A lookup made in the same cycle as an update to the same history slot or counter sees the state before that update. The update is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pred_pc | input | 10 | Branch address bits [11:2] for the lookup |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_index | output | 10 | Counter index used by this lookup |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | 6 | Resolved branch address bits [7:2] |
| upd_index | input | 10 | Counter index captured when the branch was predicted |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions assume that the inputs are free of unknowns once the internal reset is released. They also assume that no update arrives during the synchronizer cycles, because such updates are dropped by design. The counter and history properties only compare state where the next cycle's lookup happens to land on the slot or index just updated, so they hold whatever `upd_index` is. The bench waits out the reset release before driving `upd_valid`. It drives every update index from its own model, and it deliberately points lookups at recently updated slots and counters so those properties are exercised.

// File: rtl/lhp_pkg.sv
`timescale 1ns/1ps
package lhp_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_INIT = ctr_t'(1);
  localparam ctr_t CTR_MAX  = ctr_t'((1 << CTR_W) - 1);
  localparam ctr_t CTR_MIN  = ctr_t'(0);

  // saturating one-step move of a direction counter
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken) res = (cur == CTR_MAX) ? CTR_MAX : cur + ctr_t'(1);
    else       res = (cur == CTR_MIN) ? CTR_MIN : cur - ctr_t'(1);
    return res;
  endfunction

  function automatic logic ctr_dir(input ctr_t cur);
    return cur[CTR_W-1];
  endfunction
endpackage

// File: rtl/lhp_reset_sync.sv
`timescale 1ns/1ps
module lhp_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lhp_index_hash.sv
`timescale 1ns/1ps
module lhp_index_hash #(
  parameter int SLOT_W = 6,
  parameter int HIST_W = 10,
  parameter int IDX_W  = 10
) (
  input  logic [IDX_W-1:0]  pc_bits,
  input  logic [HIST_W-1:0] hist,
  output logic [SLOT_W-1:0] slot,
  output logic [IDX_W-1:0]  index
);
  logic [IDX_W-1:0] hist_fit;

  generate
    if (HIST_W == IDX_W) begin : g_same
      assign hist_fit = hist;
    end else if (HIST_W > IDX_W) begin : g_fold
      // fold the extra history bits back onto the low end
      always_comb begin
        hist_fit = '0;
        for (int b = 0; b < HIST_W; b++) begin
          hist_fit[b % IDX_W] = hist_fit[b % IDX_W] ^ hist[b];
        end
      end
    end else begin : g_pad
      assign hist_fit = {{(IDX_W-HIST_W){1'b0}}, hist};
    end
  endgenerate

  assign slot  = pc_bits[SLOT_W-1:0];
  assign index = pc_bits ^ hist_fit;
endmodule

// File: rtl/lhp_hist_table.sv
`timescale 1ns/1ps
module lhp_hist_table #(
  parameter int SLOT_W = 6,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [HIST_W-1:0] rd_hist,
  input  logic [SLOT_W-1:0] mod_slot,
  output logic [HIST_W-1:0] mod_hist,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_hist
);
  localparam int ENTRIES = 1 << SLOT_W;

  logic [HIST_W-1:0] hist_q [ENTRIES];

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic              ent_en;
      logic [HIST_W-1:0] ent_q;
      assign ent_en = wr_en && (mod_slot == SLOT_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ent_q <= '0;
        else if (ent_en) ent_q <= wr_hist;
      end
      assign hist_q[i] = ent_q;
    end
  endgenerate

  assign rd_hist  = hist_q[rd_slot];
  assign mod_hist = hist_q[mod_slot];
endmodule

// File: rtl/lhp_ctr_table.sv
`timescale 1ns/1ps
module lhp_ctr_table
  import lhp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic [IDX_W-1:0] mod_idx,
  output ctr_t             mod_ctr,
  input  logic             wr_en,
  input  ctr_t             wr_ctr
);
  localparam int ENTRIES = 1 << IDX_W;

  ctr_t ctr_q [ENTRIES];

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic ent_en;
      ctr_t ent_q;
      assign ent_en = wr_en && (mod_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ent_q <= CTR_INIT;
        else if (ent_en) ent_q <= wr_ctr;
      end
      assign ctr_q[i] = ent_q;
    end
  endgenerate

  assign rd_ctr  = ctr_q[rd_idx];
  assign mod_ctr = ctr_q[mod_idx];
endmodule

// File: rtl/lhp_predictor.sv
`timescale 1ns/1ps
module lhp_predictor
  import lhp_pkg::*;
#(
  parameter int SLOT_W    = 6,
  parameter int HIST_W    = 10,
  parameter int IDX_W     = 10,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  pred_pc,
  output logic              pred_taken,
  output logic [IDX_W-1:0]  pred_index,
  input  logic              upd_valid,
  input  logic [SLOT_W-1:0] upd_pc,
  input  logic [IDX_W-1:0]  upd_index,
  input  logic              upd_taken
);
  logic              rst_sync_n;
  logic [SLOT_W-1:0] pred_slot;
  logic [HIST_W-1:0] pred_hist;
  logic [HIST_W-1:0] upd_hist;
  logic [HIST_W-1:0] hist_next;
  ctr_t              pred_ctr;
  ctr_t              upd_ctr;
  ctr_t              ctr_next;

  lhp_reset_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lhp_index_hash #(.SLOT_W(SLOT_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_hash (
    .pc_bits (pred_pc),
    .hist    (pred_hist),
    .slot    (pred_slot),
    .index   (pred_index)
  );

  lhp_hist_table #(.SLOT_W(SLOT_W), .HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_slot  (pred_slot),
    .rd_hist  (pred_hist),
    .mod_slot (upd_pc),
    .mod_hist (upd_hist),
    .wr_en    (upd_valid),
    .wr_hist  (hist_next)
  );

  lhp_ctr_table #(.IDX_W(IDX_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_idx  (pred_index),
    .rd_ctr  (pred_ctr),
    .mod_idx (upd_index),
    .mod_ctr (upd_ctr),
    .wr_en   (upd_valid),
    .wr_ctr  (ctr_next)
  );

  // next-state for the entries named by the update
  always_comb begin
    hist_next = {upd_hist[HIST_W-2:0], upd_taken};
    ctr_next  = ctr_step(upd_ctr, upd_taken);
  end

  assign pred_taken = ctr_dir(pred_ctr);
endmodule

// File: rtl/lhp_predictor_check.sv
`timescale 1ns/1ps
module lhp_predictor_check #(
  parameter int SLOT_W = 6,
  parameter int HIST_W = 10,
  parameter int IDX_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  pred_pc,
  input logic              pred_taken,
  input logic [IDX_W-1:0]  pred_index,
  input logic [HIST_W-1:0] pred_hist,
  input logic [1:0]        pred_ctr,
  input logic              upd_valid,
  input logic [SLOT_W-1:0] upd_pc,
  input logic [IDX_W-1:0]  upd_index,
  input logic              upd_taken,
  input logic [HIST_W-1:0] upd_hist,
  input logic [1:0]        upd_ctr
);
  // R3: first cycle out of reset shows the cleared tables
  assert_reset_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pred_taken && (pred_index == pred_pc)));

  // R4: a taken update moves the named counter up, holding at 3
  assert_ctr_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=> ((pred_index != $past(upd_index)) ||
      (pred_ctr == (($past(upd_ctr) == 2'd3) ? 2'd3 : $past(upd_ctr) + 2'd1))));

  // R5: a not-taken update moves the named counter down, holding at 0
  assert_ctr_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> ((pred_index != $past(upd_index)) ||
      (pred_ctr == (($past(upd_ctr) == 2'd0) ? 2'd0 : $past(upd_ctr) - 2'd1))));

  // R6: the updated slot holds the shifted history one cycle later
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ((pred_pc[SLOT_W-1:0] != $past(upd_pc)) ||
      (pred_hist == {$past(upd_hist[HIST_W-2:0]), $past(upd_taken)})));

  // R8: without an update, a steady address keeps a steady lookup result
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> (!$stable(pred_pc) || ($stable(pred_index) && $stable(pred_taken))));
endmodule

bind lhp_predictor lhp_predictor_check #(
  .SLOT_W (SLOT_W),
  .HIST_W (HIST_W),
  .IDX_W  (IDX_W)
) u_check (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .pred_pc    (pred_pc),
  .pred_taken (pred_taken),
  .pred_index (pred_index),
  .pred_hist  (pred_hist),
  .pred_ctr   (pred_ctr),
  .upd_valid  (upd_valid),
  .upd_pc     (upd_pc),
  .upd_index  (upd_index),
  .upd_taken  (upd_taken),
  .upd_hist   (upd_hist),
  .upd_ctr    (upd_ctr)
);

// File: tb/lhp_predictor_test.sv
`timescale 1ns/1ps
module lhp_predictor_test;
  localparam int SLOT_W = 6;
  localparam int HIST_W = 10;
  localparam int IDX_W  = 10;
  localparam int NSLOT  = 1 << SLOT_W;
  localparam int NCTR   = 1 << IDX_W;
  localparam int HMASK  = (1 << HIST_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [IDX_W-1:0]  pred_pc;
  logic              pred_taken;
  logic [IDX_W-1:0]  pred_index;
  logic              upd_valid;
  logic [SLOT_W-1:0] upd_pc;
  logic [IDX_W-1:0]  upd_index;
  logic              upd_taken;

  int m_hist [NSLOT];
  int m_ctr  [NCTR];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lhp_predictor uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .pred_index (pred_index),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_index  (upd_index),
    .upd_taken  (upd_taken)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_idx(input int pcb);
    return (pcb ^ m_hist[pcb % NSLOT]) & (NCTR - 1);
  endfunction

  task automatic model_upd(input int slot, input int idx, input bit t);
    if (t) m_ctr[idx] = (m_ctr[idx] == 3) ? 3 : m_ctr[idx] + 1;
    else   m_ctr[idx] = (m_ctr[idx] == 0) ? 0 : m_ctr[idx] - 1;
    m_hist[slot] = ((m_hist[slot] << 1) | int'(t)) & HMASK;
  endtask

  // one cycle: drive at negedge, check before posedge, then apply model
  task automatic step(input bit uv, input int uslot, input int uidx, input bit ut,
                      input int ppc, input string ri, input string rt, output int used_idx);
    int e;
    @(negedge clk);
    upd_valid = uv;
    upd_pc    = SLOT_W'(uslot);
    upd_index = IDX_W'(uidx);
    upd_taken = ut;
    pred_pc   = IDX_W'(ppc);
    #5;
    e = exp_idx(ppc);
    chk(ri, int'(pred_index), e);
    chk(rt, int'(pred_taken), int'(m_ctr[e] >= 2));
    used_idx = e;
    @(posedge clk);
    if (uv) model_upd(uslot, uidx, ut);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int ix;
    int lfsr;
    int pool [8];
    int seen [8];
    int p_slot, p_idx;
    bit p_t, p_v;
    bit seq [12];

    for (int i = 0; i < NSLOT; i++) m_hist[i] = 0;
    for (int i = 0; i < NCTR; i++)  m_ctr[i] = 1;
    rst_n = 1'b0; upd_valid = 1'b0; upd_pc = '0; upd_index = '0; upd_taken = 1'b0; pred_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: every lookup reads cleared state; junk on idle update fields
    for (int p = 0; p < NCTR; p++)
      step(1'b0, p * 5, p * 3, p[0], p, "R3 index", "R3 taken", ix);

    // R8: idle update fields leave all state unchanged
    for (int p = NCTR - 1; p >= 0; p--)
      step(1'b0, p, NCTR - 1 - p, 1'b1, p, "R8 index", "R8 taken", ix);

    // R4/R5/R7: train counter 0x3A5 through slot 1, observe it via address 0x3A5
    seq = '{1,1,1,1,1,0,0,0,0,0,1,1};
    for (int k = 0; k < 12; k++)
      step(1'b1, 1, 'h3A5, seq[k], 'h3A5, "R7 index",
           (k < 6) ? "R4 taken" : (k < 11 ? "R5 taken" : "R7 taken"), ix);
    step(1'b0, 0, 0, 1'b0, 'h3A5, "R7 index", "R4 taken after rise", ix);

    // R6: slot 1 history after twelve outcomes, seen through several addresses
    for (int k = 0; k < 16; k++)
      step(1'b0, 0, 0, 1'b0, 1 + (k << SLOT_W), "R6 index", "R6 taken", ix);

    // R9: same-cycle update and lookup on slot 5
    step(1'b0, 0, 0, 1'b0, 5, "R9 index before", "R9 taken before", ix);
    p_idx = ix;
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 5, p_idx, 1'b1, 5, "R9 index same cycle", "R9 taken same cycle", ix);
      p_idx = ix;
    end
    step(1'b0, 0, 0, 1'b0, 5, "R9 index after", "R9 taken after", ix);

    // R1/R2: pipelined training over a branch pool with shared slots
    pool = '{'h041, 'h081, 'h2C7, 'h13A, 'h3FF, 'h200, 'h155, 'h0AA};
    seen = '{0,0,0,0,0,0,0,0};
    lfsr = 'hACE1;
    p_v = 1'b0; p_slot = 0; p_idx = 0; p_t = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      int b;
      int pcb;
      bit t;
      lfsr = ((lfsr >> 1) | ((((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 'hFFFF;
      b   = lfsr % 8;
      pcb = pool[b];
      step(p_v, p_slot, p_idx, p_t, pcb, "R1 index", "R2 taken", ix);
      seen[b]++;
      t = (b == 7) ? lfsr[9] : ((seen[b] % (b + 2)) != 0);
      p_v = 1'b1; p_slot = pcb % NSLOT; p_idx = ix; p_t = t;
    end
    step(p_v, p_slot, p_idx, p_t, pool[0], "R1 index", "R2 taken", ix);
    step(1'b0, 0, 0, 1'b0, pool[0], "R1 index", "R2 taken", ix);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule